// File: doc/BRIEF.md
# Memory Traffic and Cycle Profiling Counters

This block holds a bank of free-running profiling counters that a host reads and writes through a plain word-addressed register port. Seven counters track traffic on a memory bus. Two of them sum data volume in 64-bit units. The others count write requests, write data beats, read requests, read data beats and read beats that close a burst. Each kind of bus event arrives on its own one-cycle strobe. A halt register clears all seven traffic counters and keeps them at zero until it is written back to zero.

Two more counters measure time. One advances on every clock. The other advances only on clocks where every engine in the idle vector reports idle, with the fetch engine left out of that test. A write of any value to the cycle counter's address clears both of these counters.

The register port is a control path, so it has no handshake. A write lands at the clock edge where `reg_wr` is high. A read is purely combinational: it returns the state left by the most recent edge and changes nothing. No pin carries a data stream, so no pin carries back-pressure.

Top module: `bus_prof_counters`

## Requirements
- R1: After reset every counter reads 0 and the halt register reads 0, so counting is enabled.
- R2: Register map, by word address: 0 is the halt control, with the halt flag in bit 0 and bits 31..1 reading 0. Addresses 1 to 7 are the traffic counters: read units, write units, write beats, write requests, read beats, read requests, read-last beats. Address 8 is the cycle counter and address 9 is the idle-cycle counter. Writing 1 in bit 0 of address 0 clears all seven traffic counters at that edge and holds them at 0 for as long as the flag stays set. The cycle and idle counters are not affected.
- R3: Writing 0 in bit 0 of address 0 re-enables the traffic counters. Events strobed in the same cycle as that write are already counted.
- R4: The read-unit and write-unit counters add DATA_W/64 for each read or write data beat, so one step is one 64-bit unit.
- R5: The beat, request and read-last counters each add exactly 1 for each cycle in which their strobe is high. The strobes are independent, and any mix of them may be high in the same cycle.
- R6: The cycle counter adds 1 on every clock and wraps from its maximum value to 0.
- R7: A write of any data to address 8 clears both the cycle counter and the idle counter at that edge. The clear takes priority over that cycle's increment, so both read 0 after the edge.
- R8: The idle counter adds 1 only on cycles where every bit of `eng_idle` is 1, except bit FETCH_IDX, whose value is ignored.
- R9: Reads have no side effects, reflect the state as of the last clock edge, and return 0 at addresses 10 to 15. Writes to any address other than 0 and 8 change nothing.
- R10: Every counter is CNT_W bits wide, is read zero-extended to 32 bits, and wraps silently to 0 on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rd_req | input | 1 | Read request accepted this cycle |
| ev_wr_req | input | 1 | Write request accepted this cycle |
| ev_rd_beat | input | 1 | Read data beat transferred this cycle |
| ev_wr_beat | input | 1 | Write data beat transferred this cycle |
| ev_rd_last | input | 1 | Final beat of a read burst this cycle |
| eng_idle | input | N_ENG | Per-engine idle flags, where 1 means idle |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read word address |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
The bench builds the block with CNT_W=10, DATA_W=128, N_ENG=5 and FETCH_IDX=2. With 10-bit counters, the cycle counter and the heavily strobed unit counters wrap within about a thousand cycles, which brings the R10 wrap behaviour within reach of a short run. A 128-bit data path makes each unit step equal to 2, so a unit counter cannot be confused with its beat counter. Putting the fetch engine in the middle of the vector checks that the right bit is masked, rather than bit 0 by coincidence.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int NUM_MEM = 7;
  localparam int REG_AW  = 4;

  // traffic counter slots; slot k is read at word address k+1
  localparam int MI_RD_UNITS = 0;
  localparam int MI_WR_UNITS = 1;
  localparam int MI_WR_BEATS = 2;
  localparam int MI_WR_REQS  = 3;
  localparam int MI_RD_BEATS = 4;
  localparam int MI_RD_REQS  = 5;
  localparam int MI_RD_LASTS = 6;

  localparam logic [REG_AW-1:0] A_HALT     = 4'd0;
  localparam logic [REG_AW-1:0] A_MEM_BASE = 4'd1;
  localparam logic [REG_AW-1:0] A_CYCLES   = 4'd8;
  localparam logic [REG_AW-1:0] A_IDLE     = 4'd9;
endpackage

// File: rtl/prof_counter.sv
module prof_counter #(
  parameter int W      = 32,
  parameter int STEP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      count
);
  // clear has priority over increment; the sum wraps at W bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + W'(step);
  end
endmodule

// File: rtl/prof_mem_bank.sv
module prof_mem_bank
  import prof_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int UNITS  = 1,
  parameter int STEP_W = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            halt,
  input  logic [NUM_MEM-1:0]              ev,
  output logic [NUM_MEM-1:0][CNT_W-1:0]   cnt
);
  for (genvar i = 0; i < NUM_MEM; i++) begin : g_cnt
    localparam int STEP_V = (i == MI_RD_UNITS || i == MI_WR_UNITS) ? UNITS : 1;
    prof_counter #(.W(CNT_W), .STEP_W(STEP_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (halt),
      .inc   (ev[i]),
      .step  (STEP_W'(STEP_V)),
      .count (cnt[i])
    );
  end
endmodule

// File: rtl/prof_cycle_unit.sv
module prof_cycle_unit #(
  parameter int CNT_W     = 32,
  parameter int N_ENG     = 12,
  parameter int FETCH_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N_ENG-1:0] eng_idle,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] idle_cnt
);
  localparam logic [N_ENG-1:0] FETCH_MASK = N_ENG'(1) << FETCH_IDX;

  logic others_idle;
  assign others_idle = &(eng_idle | FETCH_MASK);

  prof_counter #(.W(CNT_W), .STEP_W(1)) u_cyc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(1'b1), .step(1'b1), .count(cyc_cnt)
  );

  prof_counter #(.W(CNT_W), .STEP_W(1)) u_idle (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(others_idle), .step(1'b1), .count(idle_cnt)
  );
endmodule

// File: rtl/bus_prof_counters.sv
module bus_prof_counters
  import prof_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DATA_W    = 64,
  parameter int N_ENG     = 12,
  parameter int FETCH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd_req,
  input  logic              ev_wr_req,
  input  logic              ev_rd_beat,
  input  logic              ev_wr_beat,
  input  logic              ev_rd_last,
  input  logic [N_ENG-1:0]  eng_idle,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [31:0]       reg_rdata
);
  localparam int UNITS  = DATA_W / 64;
  localparam int STEP_W = $clog2(UNITS + 1);

  logic                          halt_q;
  logic                          halt_next;
  logic                          cyc_clr;
  logic [NUM_MEM-1:0]            mem_ev;
  logic [NUM_MEM-1:0][CNT_W-1:0] mem_cnt;
  logic [CNT_W-1:0]              cyc_cnt;
  logic [CNT_W-1:0]              idle_cnt;

  // a write to the halt register takes effect at its own edge
  assign halt_next = (reg_wr && reg_waddr == A_HALT) ? reg_wdata[0] : halt_q;
  assign cyc_clr   = reg_wr && reg_waddr == A_CYCLES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_next;
  end

  always_comb begin
    mem_ev              = '0;
    mem_ev[MI_RD_UNITS] = ev_rd_beat;
    mem_ev[MI_WR_UNITS] = ev_wr_beat;
    mem_ev[MI_WR_BEATS] = ev_wr_beat;
    mem_ev[MI_WR_REQS]  = ev_wr_req;
    mem_ev[MI_RD_BEATS] = ev_rd_beat;
    mem_ev[MI_RD_REQS]  = ev_rd_req;
    mem_ev[MI_RD_LASTS] = ev_rd_last;
  end

  prof_mem_bank #(.CNT_W(CNT_W), .UNITS(UNITS), .STEP_W(STEP_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt_next),
    .ev    (mem_ev),
    .cnt   (mem_cnt)
  );

  prof_cycle_unit #(.CNT_W(CNT_W), .N_ENG(N_ENG), .FETCH_IDX(FETCH_IDX)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cyc_clr),
    .eng_idle (eng_idle),
    .cyc_cnt  (cyc_cnt),
    .idle_cnt (idle_cnt)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == A_HALT)   reg_rdata[0] = halt_q;
    if (reg_raddr == A_CYCLES) reg_rdata = 32'(cyc_cnt);
    if (reg_raddr == A_IDLE)   reg_rdata = 32'(idle_cnt);
    for (int i = 0; i < NUM_MEM; i++) begin
      if (reg_raddr == REG_AW'(int'(A_MEM_BASE) + i)) reg_rdata = 32'(mem_cnt[i]);
    end
  end
endmodule

// File: rtl/prof_checker.sv
module prof_checker
  import prof_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int UNITS     = 1,
  parameter int N_ENG     = 12,
  parameter int FETCH_IDX = 0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ev_wr_req,
  input logic                          ev_rd_beat,
  input logic                          ev_rd_last,
  input logic [N_ENG-1:0]              eng_idle,
  input logic                          reg_wr,
  input logic [REG_AW-1:0]             reg_waddr,
  input logic [31:0]                   reg_wdata,
  input logic                          halt_q,
  input logic [NUM_MEM-1:0][CNT_W-1:0] mem_cnt,
  input logic [CNT_W-1:0]              cyc_cnt,
  input logic [CNT_W-1:0]              idle_cnt
);
  logic             halt_wr;
  logic             run_now;
  logic             cyc_wr;
  logic             idle_ok;
  logic [CNT_W-1:0] units_plus;
  logic [CNT_W-1:0] wreq_plus;
  logic [CNT_W-1:0] last_plus;
  logic [CNT_W-1:0] cyc_plus;

  assign halt_wr    = reg_wr && reg_waddr == 4'd0;
  assign run_now    = halt_wr ? !reg_wdata[0] : !halt_q;
  assign cyc_wr     = reg_wr && reg_waddr == 4'd8;
  assign units_plus = mem_cnt[MI_RD_UNITS] + CNT_W'(UNITS);
  assign wreq_plus  = mem_cnt[MI_WR_REQS] + 1'b1;
  assign last_plus  = mem_cnt[MI_RD_LASTS] + 1'b1;
  assign cyc_plus   = cyc_cnt + 1'b1;

  always_comb begin
    idle_ok = 1'b1;
    for (int i = 0; i < N_ENG; i++)
      if (i != FETCH_IDX && !eng_idle[i]) idle_ok = 1'b0;
  end

  AST_HALT_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> mem_cnt == '0);                                                 // R2
  AST_RESUME_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_wr && !reg_wdata[0] && ev_rd_last) |=> mem_cnt[MI_RD_LASTS] == $past(last_plus)); // R3
  AST_UNIT_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_beat && run_now) |=> mem_cnt[MI_RD_UNITS] == $past(units_plus));   // R4
  AST_REQ_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_req && run_now) |=> mem_cnt[MI_WR_REQS] == $past(wreq_plus));      // R5
  AST_CYC_STEP:    assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wr |=> cyc_cnt == $past(cyc_plus));                                  // R6
  AST_CYC_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> (cyc_cnt == '0 && idle_cnt == '0));                            // R7
  AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ok && !cyc_wr) |=> $stable(idle_cnt));                             // R8
endmodule

bind bus_prof_counters prof_checker #(
  .CNT_W(CNT_W), .UNITS(UNITS), .N_ENG(N_ENG), .FETCH_IDX(FETCH_IDX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_wr_req  (ev_wr_req),
  .ev_rd_beat (ev_rd_beat),
  .ev_rd_last (ev_rd_last),
  .eng_idle   (eng_idle),
  .reg_wr     (reg_wr),
  .reg_waddr  (reg_waddr),
  .reg_wdata  (reg_wdata),
  .halt_q     (halt_q),
  .mem_cnt    (mem_cnt),
  .cyc_cnt    (cyc_cnt),
  .idle_cnt   (idle_cnt)
);

// File: tb/bus_prof_counters_bench.sv
module bus_prof_counters_bench;
  localparam int CLK_P     = 40;
  localparam int CNT_W     = 10;
  localparam int DATA_W    = 128;
  localparam int N_ENG     = 5;
  localparam int FETCH_IDX = 2;
  localparam int UNITS     = DATA_W / 64;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             ev_rd_req, ev_wr_req, ev_rd_beat, ev_wr_beat, ev_rd_last;
  logic [N_ENG-1:0] eng_idle;
  logic             reg_wr;
  logic [3:0]       reg_waddr;
  logic [31:0]      reg_wdata;
  logic [3:0]       reg_raddr;
  logic [31:0]      reg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  string phase_tag = "";

  logic [CNT_W-1:0] m_mem [7];
  logic [CNT_W-1:0] m_cyc, m_idle;
  logic             m_halt;

  always #(CLK_P/2) clk = ~clk;

  bus_prof_counters #(.CNT_W(CNT_W), .DATA_W(DATA_W), .N_ENG(N_ENG), .FETCH_IDX(FETCH_IDX))
  u_bus_prof_counters (
    .clk(clk), .rst_n(rst_n), .ev_rd_req(ev_rd_req), .ev_wr_req(ev_wr_req),
    .ev_rd_beat(ev_rd_beat), .ev_wr_beat(ev_wr_beat), .ev_rd_last(ev_rd_last),
    .eng_idle(eng_idle), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  function automatic string req_of(int a);
    if (a == 0) return "R2";
    if (a == 1 || a == 2) return "R4";
    if (a >= 3 && a <= 7) return "R5";
    if (a == 8) return "R6";
    if (a == 9) return "R8";
    return "R9";
  endfunction

  function automatic logic [31:0] expect_of(int a);
    if (a == 0) return {31'b0, m_halt};
    if (a >= 1 && a <= 7) return 32'(m_mem[a-1]);
    if (a == 8) return 32'(m_cyc);
    if (a == 9) return 32'(m_idle);
    return 32'b0;
  endfunction

  function automatic logic others_idle(logic [N_ENG-1:0] v);
    logic [N_ENG-1:0] m;
    m = v;
    m[FETCH_IDX] = 1'b1;
    return m == {N_ENG{1'b1}};
  endfunction

  task automatic model_update();
    logic hn;
    hn = (reg_wr && reg_waddr == 4'd0) ? reg_wdata[0] : m_halt;
    if (ev_rd_beat) m_mem[0] = m_mem[0] + CNT_W'(UNITS);
    if (ev_wr_beat) m_mem[1] = m_mem[1] + CNT_W'(UNITS);
    if (ev_wr_beat) m_mem[2] = m_mem[2] + 1'b1;
    if (ev_wr_req)  m_mem[3] = m_mem[3] + 1'b1;
    if (ev_rd_beat) m_mem[4] = m_mem[4] + 1'b1;
    if (ev_rd_req)  m_mem[5] = m_mem[5] + 1'b1;
    if (ev_rd_last) m_mem[6] = m_mem[6] + 1'b1;
    if (hn) for (int k = 0; k < 7; k++) m_mem[k] = '0;
    m_halt = hn;
    if (reg_wr && reg_waddr == 4'd8) begin
      m_cyc = '0; m_idle = '0;
    end else begin
      m_cyc = m_cyc + 1'b1;
      if (others_idle(eng_idle)) m_idle = m_idle + 1'b1;
    end
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      string tag;
      logic [31:0] exp;
      reg_raddr = 4'(a);
      #1;
      exp = expect_of(a);
      tag = (phase_tag != "") ? phase_tag : req_of(a);
      n_cmp++;
      if (reg_rdata !== exp) begin
        n_bad++;
        $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
      end
    end
  endtask

  task automatic drive(logic [4:0] ev, logic [N_ENG-1:0] idl, logic w, logic [3:0] wa, logic [31:0] wd);
    {ev_rd_req, ev_wr_req, ev_rd_beat, ev_wr_beat, ev_rd_last} = ev;
    eng_idle = idl; reg_wr = w; reg_waddr = wa; reg_wdata = wd;
  endtask

  // inputs applied at the falling edge; state checked before the next rising edge
  task automatic step(logic [4:0] ev, logic [N_ENG-1:0] idl, logic w, logic [3:0] wa, logic [31:0] wd);
    drive(ev, idl, w, wa, wd);
    sweep();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic random_steps(int n);
    for (int i = 0; i < n; i++) begin
      logic [N_ENG-1:0] idl;
      logic w;
      idl = ($urandom % 2) ? {N_ENG{1'b1}} : N_ENG'($urandom);
      w = ($urandom % 20) == 0;
      step(5'($urandom), idl, w, 4'($urandom), $urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int k = 0; k < 7; k++) m_mem[k] = '0;
    m_cyc = '0; m_idle = '0; m_halt = 1'b0;
    rst_n = 1'b0;
    drive(5'b0, '0, 1'b0, 4'd0, 32'd0);
    reg_raddr = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase_tag = "R1";
    sweep();
    phase_tag = "";
    @(posedge clk); model_update(); @(negedge clk);

    random_steps(300);

    // halt with every strobe high, then hold
    phase_tag = "R2";
    step(5'b11111, {N_ENG{1'b1}}, 1'b1, 4'd0, 32'h1);
    for (int i = 0; i < 5; i++) step(5'b11111, {N_ENG{1'b1}}, 1'b0, 4'd3, 32'd0);

    // resume: strobes in the releasing cycle already count
    phase_tag = "R3";
    step(5'b11111, {N_ENG{1'b1}}, 1'b1, 4'd0, 32'hFFFF_FFFE);
    step(5'b10101, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);
    step(5'b00000, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);

    // any data clears cycle and idle, beating the same-cycle increment
    phase_tag = "R7";
    step(5'b0, {N_ENG{1'b1}}, 1'b1, 4'd8, 32'hDEAD_BEEF);
    step(5'b0, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);
    step(5'b0, {N_ENG{1'b1}}, 1'b1, 4'd8, 32'd0);
    step(5'b0, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);

    // fetch busy is ignored, any other busy engine stops the idle count
    phase_tag = "R8";
    for (int i = 0; i < 5; i++) step(5'b0, 5'b11011, 1'b0, 4'd0, 32'd0);
    for (int i = 0; i < 3; i++) step(5'b0, 5'b11110, 1'b0, 4'd0, 32'd0);
    step(5'b0, 5'b01111, 1'b0, 4'd0, 32'd0);
    step(5'b0, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);

    // writes to read-only or unmapped addresses change nothing
    phase_tag = "R9";
    step(5'b0, {N_ENG{1'b1}}, 1'b1, 4'd9, 32'hFFFF_FFFF);
    step(5'b0, {N_ENG{1'b1}}, 1'b1, 4'd4, 32'h0);
    step(5'b0, {N_ENG{1'b1}}, 1'b1, 4'd13, 32'h1);
    step(5'b0, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);

    // long saturated run to wrap every counter width
    phase_tag = "R10";
    for (int i = 0; i < 1100; i++) step(5'b11111, {N_ENG{1'b1}}, 1'b0, 4'd0, 32'd0);

    phase_tag = "";
    random_steps(600);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule